// File: doc/BRIEF.md
# Two-Channel Potentiometer Serial Register Interface

This block is the serial target front end of a two-channel digital potentiometer. It watches an I2C bus whose SCL and SDA lines have already been synchronised and oversampled by the system clock. It pulls SDA low through an open-drain enable when it acknowledges or sends a zero. It holds one wiper register per channel, a channel pointer, a shutdown control bit and two general-purpose logic outputs.

A write transfer carries the target address, then one command byte, then any number of value bytes. Every value byte lands in the wiper that the command selected, until the STOP. A read transfer carries only the address. The target then streams the wiper of the channel picked by the most recent command. It keeps sending for as long as the controller acknowledges. The controller may issue a command, then a repeated START, then a read, to fetch one channel without touching its value.

Top module: `i2cpot_top`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts address reception from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. Bytes sent after a STOP and before the next START get no acknowledge.
- R2: The address byte is `0 1 0 1 1 AD1 AD0 RW`, sent MSB first, with RW=1 meaning read. The block acknowledges only when bits 2:1 equal `addr_pins_i[1:0]`. If they differ, it keeps SDA released and ignores the bus until the next START.
- R3: Each unit is nine SCL clocks: eight bits MSB first, then an acknowledge bit. The block changes `sda_oe_o` only while SCL is low, except when a START or STOP forces it to release. It releases SDA after its acknowledge clock.
- R4: In a write, the byte after the address is the command byte. Bit 7 is the channel (0 = `wiper_a_o`, 1 = `wiper_b_o`). Bit 5 is the shutdown bit, where 0 asserts shutdown. Bit 4 goes to `gpo2_o` and bit 3 goes to `gpo1_o`. Bits 2:0 have no effect. The command byte is acknowledged.
- R5: Command bit 6 = 1 loads 8'h80 into the wiper of the channel named by bit 7.
- R6: Every byte after the command byte, until STOP or START, is acknowledged and written to the selected wiper. The other wiper stays unchanged.
- R7: In a read, the first data byte follows the address acknowledge and holds the selected wiper, MSB first. After a controller acknowledge, the block sends the value again. After a not-acknowledge, it releases SDA.
- R8: A command byte followed directly by a repeated START and a read returns the wiper of the channel that this command selected.
- R9: After reset both wipers hold 8'h80, channel A is selected, `gpo1_o` and `gpo2_o` are 0, the shutdown bit is inactive and `sda_oe_o` is 0.
- R10: `shutdown_o` is 1 when `shdn_n_i` is low or when the stored shutdown bit is 0. Wiper values are kept while shutdown is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus) |
| addr_pins_i | input | 2 | Strapped address bits {AD1, AD0} |
| shdn_n_i | input | 1 | External shutdown, active low |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wiper_a_o | output | 8 | Channel A wiper value |
| wiper_b_o | output | 8 | Channel B wiper value |
| chan_sel_o | output | 1 | Currently selected channel |
| shutdown_o | output | 1 | Shutdown asserted |
| gpo1_o | output | 1 | General-purpose output 1 |
| gpo2_o | output | 1 | General-purpose output 2 |

## Verification
A command byte can set the channel pointer and request a midscale load, and both take effect in the same clock. The read launched by a repeated START right after that command must see the new channel holding 8'h80. The bench provokes this by sending that command, then a repeated START and a read, with no value byte and no STOP. It judges the result by the byte read back and the wiper output ports. A second overlap is a START that arrives while a byte is half received. The bench sends three stray bits, then a repeated START, and checks that the next address still gets an acknowledge.

// File: rtl/i2cpot_pkg.sv
package i2cpot_pkg;
  localparam int BYTE_W = 8;
  localparam int NCH    = 2;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;

  // command byte field positions
  localparam int CMD_CH  = 7;
  localparam int CMD_MID = 6;
  localparam int CMD_SD  = 5;
  localparam int CMD_O2  = 4;
  localparam int CMD_O1  = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK_PEND, PH_ACK, PH_TX, PH_TX_ACK
  } phase_t;

  typedef enum logic [1:0] {
    RX_ADDR, RX_CMD, RX_DATA
  } rxkind_t;
endpackage

// File: rtl/i2cpot_buscond.sv
module i2cpot_buscond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
    start_det = scl_i & scl_q & sda_q & ~sda_i;
    stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2cpot_link.sv
module i2cpot_link
  import i2cpot_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b01011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_i,
  input  logic [1:0]        addr_pins,
  input  logic [BYTE_W-1:0] rd_value,
  output logic              sda_oe,
  output logic              addr_done,
  output logic              addr_match,
  output logic              cmd_we,
  output logic              data_we,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_t            phase_q, phase_d;
  rxkind_t           kind_q, kind_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              to_tx_q, to_tx_d;
  logic              mack_q, mack_d;
  logic [BYTE_W-1:0] rx_full;
  logic              byte_done;

  always_comb begin
    rx_full    = {sh_q[BYTE_W-2:0], sda_i};
    byte_done  = (phase_q == PH_RX) && scl_rise && (bit_q == LAST_BIT);
    addr_match = (rx_full[7:3] == ADDR_HI) && (rx_full[2:1] == addr_pins);
    addr_done  = byte_done && (kind_q == RX_ADDR);
    cmd_we     = byte_done && (kind_q == RX_CMD);
    data_we    = byte_done && (kind_q == RX_DATA);
    rx_byte    = rx_full;
    sda_oe     = (phase_q == PH_ACK) || ((phase_q == PH_TX) && !tx_q[BYTE_W-1]);
  end

  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    to_tx_d = to_tx_q;
    mack_d  = mack_q;
    unique case (phase_q)
      PH_IDLE: ;
      PH_RX: if (scl_rise) begin
        sh_d = rx_full;
        if (bit_q == LAST_BIT) begin
          bit_d = '0;
          unique case (kind_q)
            RX_ADDR: begin
              if (addr_match) begin
                phase_d = PH_ACK_PEND;
                to_tx_d = rx_full[0];
                kind_d  = RX_CMD;
              end else begin
                phase_d = PH_IDLE;
              end
            end
            RX_CMD, RX_DATA: begin
              phase_d = PH_ACK_PEND;
              to_tx_d = 1'b0;
              kind_d  = RX_DATA;
            end
            default: phase_d = PH_IDLE;
          endcase
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      PH_ACK_PEND: if (scl_fall) phase_d = PH_ACK;
      PH_ACK: if (scl_fall) begin
        bit_d = '0;
        if (to_tx_q) begin
          phase_d = PH_TX;
          tx_d    = rd_value;
        end else begin
          phase_d = PH_RX;
        end
      end
      PH_TX: if (scl_fall) begin
        if (bit_q == LAST_BIT) begin
          phase_d = PH_TX_ACK;
          bit_d   = '0;
        end else begin
          tx_d  = {tx_q[BYTE_W-2:0], 1'b1};
          bit_d = bit_q + 1'b1;
        end
      end
      PH_TX_ACK: begin
        if (scl_rise) mack_d = ~sda_i;
        if (scl_fall) begin
          if (mack_q) begin
            phase_d = PH_TX;
            tx_d    = rd_value;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    if (start_det) begin
      phase_d = PH_RX;
      kind_d  = RX_ADDR;
      bit_d   = '0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= RX_ADDR;
      bit_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '1;
      to_tx_q <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      kind_q  <= kind_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      to_tx_q <= to_tx_d;
      mack_q  <= mack_d;
    end
  end
endmodule

// File: rtl/i2cpot_regs.sv
module i2cpot_regs
  import i2cpot_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_we,
  input  logic                  data_we,
  input  logic [BYTE_W-1:0]     wbyte,
  input  logic                  shdn_n_i,
  output logic [NCH*BYTE_W-1:0] wipers,
  output logic [BYTE_W-1:0]     rd_value,
  output logic [CH_W-1:0]       chan_sel,
  output logic                  gpo1,
  output logic                  gpo2,
  output logic                  shutdown
);
  localparam logic [BYTE_W-1:0] MIDSCALE = BYTE_W'(1) << (BYTE_W - 1);

  logic [BYTE_W-1:0] wip_q [NCH];
  logic [CH_W-1:0]   ch_q, ch_d;
  logic              sd_q, sd_d, o1_q, o1_d, o2_q, o2_d;
  logic [CH_W-1:0]   cmd_ch;

  assign cmd_ch = CH_W'(wbyte[CMD_CH]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [BYTE_W-1:0] wip_d;
    always_comb begin
      wip_d = wip_q[c];
      if (cmd_we && wbyte[CMD_MID] && (cmd_ch == CH_W'(c)))
        wip_d = MIDSCALE;
      else if (data_we && (ch_q == CH_W'(c)))
        wip_d = wbyte;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wip_q[c] <= MIDSCALE;
      else        wip_q[c] <= wip_d;
    end
    assign wipers[c*BYTE_W +: BYTE_W] = wip_q[c];
  end

  always_comb begin
    ch_d = ch_q;
    sd_d = sd_q;
    o1_d = o1_q;
    o2_d = o2_q;
    if (cmd_we) begin
      ch_d = cmd_ch;
      sd_d = wbyte[CMD_SD];
      o2_d = wbyte[CMD_O2];
      o1_d = wbyte[CMD_O1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
      sd_q <= 1'b1;
      o1_q <= 1'b0;
      o2_q <= 1'b0;
    end else begin
      ch_q <= ch_d;
      sd_q <= sd_d;
      o1_q <= o1_d;
      o2_q <= o2_d;
    end
  end

  assign rd_value = wip_q[ch_q];
  assign chan_sel = ch_q;
  assign gpo1     = o1_q;
  assign gpo2     = o2_q;
  assign shutdown = ~shdn_n_i | ~sd_q;
endmodule

// File: rtl/i2cpot_top.sv
module i2cpot_top
  import i2cpot_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b01011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_pins_i,
  input  logic       shdn_n_i,
  output logic       sda_oe_o,
  output logic [7:0] wiper_a_o,
  output logic [7:0] wiper_b_o,
  output logic       chan_sel_o,
  output logic       shutdown_o,
  output logic       gpo1_o,
  output logic       gpo2_o
);
  logic scl_rise, scl_fall, start_det, stop_det;
  logic addr_done, addr_match, cmd_we, data_we;
  logic [BYTE_W-1:0]     rx_byte, rd_value;
  logic [NCH*BYTE_W-1:0] wipers;
  logic [CH_W-1:0]       chan_sel;

  i2cpot_buscond u_bus (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cpot_link #(.ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_i(sda_i),
    .addr_pins(addr_pins_i), .rd_value(rd_value), .sda_oe(sda_oe_o),
    .addr_done(addr_done), .addr_match(addr_match),
    .cmd_we(cmd_we), .data_we(data_we), .rx_byte(rx_byte)
  );

  i2cpot_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .data_we(data_we),
    .wbyte(rx_byte), .shdn_n_i(shdn_n_i), .wipers(wipers),
    .rd_value(rd_value), .chan_sel(chan_sel), .gpo1(gpo1_o),
    .gpo2(gpo2_o), .shutdown(shutdown_o)
  );

  assign wiper_a_o  = wipers[0 +: BYTE_W];
  assign wiper_b_o  = wipers[BYTE_W +: BYTE_W];
  assign chan_sel_o = chan_sel[0];
endmodule

// File: rtl/i2cpot_chk.sv
module i2cpot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       shdn_n_i,
  input logic       sda_oe_o,
  input logic [7:0] wiper_a_o,
  input logic [7:0] wiper_b_o,
  input logic       gpo1_o,
  input logic       gpo2_o,
  input logic       shutdown_o,
  input logic       start_det,
  input logic       stop_det,
  input logic       addr_done,
  input logic       addr_match,
  input logic       cmd_we,
  input logic       data_we
);
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);

  p_nomatch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_match) |=> !sda_oe_o);

  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(start_det || stop_det)) |-> !scl_i);

  p_gpo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable({gpo1_o, gpo2_o}));

  p_wiper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we && !data_we) |=> $stable({wiper_a_o, wiper_b_o}));

  p_pin_shutdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_i |-> shutdown_o);
endmodule

bind i2cpot_top i2cpot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .shdn_n_i(shdn_n_i),
  .sda_oe_o(sda_oe_o), .wiper_a_o(wiper_a_o), .wiper_b_o(wiper_b_o),
  .gpo1_o(gpo1_o), .gpo2_o(gpo2_o), .shutdown_o(shutdown_o),
  .start_det(start_det), .stop_det(stop_det), .addr_done(addr_done),
  .addr_match(addr_match), .cmd_we(cmd_we), .data_we(data_we)
);

// File: tb/sim_i2cpot_top.sv
`timescale 1ns/1ps
module sim_i2cpot_top;
  logic clk, rst_n;
  logic scl, sda_m;
  logic [1:0] pins;
  logic shdn_n;
  logic sda_oe;
  logic [7:0] wa, wb;
  logic chs, shd, g1, g2;
  logic bus_sda;
  int checks, fails;
  bit done;

  assign bus_sda = sda_m & ~sda_oe;

  i2cpot_top u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda),
    .addr_pins_i(pins), .shdn_n_i(shdn_n), .sda_oe_o(sda_oe),
    .wiper_a_o(wa), .wiper_b_o(wb), .chan_sel_o(chs),
    .shutdown_o(shd), .gpo1_o(g1), .gpo2_o(g2)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [7:0] WADDR = 8'h5C; // 01011 10 0
  localparam logic [7:0] RADDR = 8'h5D;

  // {command, data, exp_o2, exp_o1, exp_shutdown}
  localparam int NV = 4;
  localparam logic [18:0] VEC [NV] = '{
    {8'h38, 8'h5A, 1'b1, 1'b1, 1'b0},
    {8'h87, 8'hC3, 1'b0, 1'b0, 1'b1},
    {8'h30, 8'h11, 1'b1, 1'b0, 1'b0},
    {8'hA8, 8'hFE, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hold();
    repeat (4) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; hold();
    scl = 1'b1; hold();
    scl = 1'b0; hold();
  endtask

  task automatic do_start();
    sda_m = 1'b1; scl = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl = 1'b0; hold();
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; hold();
    scl = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl = 1'b0; hold();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; hold();
    scl = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; hold();
    scl = 1'b1; hold();
    ack = ~bus_sda;
    scl = 1'b0; hold();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hold();
      scl = 1'b1; hold();
      b[i] = bus_sda;
      scl = 1'b0; hold();
    end
    sda_m = ~give_ack; hold();
    scl = 1'b1; hold();
    scl = 1'b0; hold();
    sda_m = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic ack;
    logic [7:0] rb;
    checks = 0; fails = 0; done = 1'b0;
    scl = 1'b1; sda_m = 1'b1; pins = 2'b10; shdn_n = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hold();

    // R9 reset state
    chk(wa == 8'h80 && wb == 8'h80, "R9 wipers midscale", wa ^ wb, 8'h00);
    chk(!g1 && !g2 && !shd && !chs, "R9 outputs idle", {4'h0, g1, g2, shd, chs}, 8'h00);
    chk(!sda_oe, "R9 sda released", {7'h0, sda_oe}, 8'h00);

    // table: R4 R6 R8 R7
    for (int v = 0; v < NV; v++) begin
      logic [7:0] cmd, dat;
      logic eo2, eo1, esd;
      {cmd, dat, eo2, eo1, esd} = VEC[v];
      do_start();
      send_byte(WADDR, ack);
      chk(ack, "R2 address ack", {7'h0, ack}, 8'h01);
      send_byte(cmd, ack);
      chk(ack, "R4 command ack", {7'h0, ack}, 8'h01);
      send_byte(dat, ack);
      chk(ack, "R6 data ack", {7'h0, ack}, 8'h01);
      do_stop();
      chk((cmd[7] ? wb : wa) == dat, "R6 wiper written", cmd[7] ? wb : wa, dat);
      chk({g2, g1} == {eo2, eo1}, "R4 gpo bits", {6'h0, g2, g1}, {6'h0, eo2, eo1});
      chk(shd == esd, "R4 shutdown bit", {7'h0, shd}, {7'h0, esd});
      do_start();
      send_byte(WADDR, ack);
      send_byte(cmd, ack);
      do_rstart();
      send_byte(RADDR, ack);
      chk(ack, "R7 read address ack", {7'h0, ack}, 8'h01);
      recv_byte(1'b0, rb);
      do_stop();
      chk(rb == dat, "R8 readback after repeated start", rb, dat);
    end
    // now: wa=11, wb=FE, ch B, O1=1 O2=0, SD inactive

    // R2 mismatch address (pins 00 instead of 10)
    do_start();
    send_byte(8'h58, ack);
    chk(!ack, "R2 mismatch no ack", {7'h0, ack}, 8'h00);
    send_byte(8'h20, ack);
    chk(!ack, "R2 ignored after mismatch", {7'h0, ack}, 8'h00);
    send_byte(8'h77, ack);
    do_stop();
    chk(wa == 8'h11 && wb == 8'hFE && g1 && !g2, "R2 state untouched", wb, 8'hFE);

    // R1 stray bits then repeated START mid-byte
    do_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    do_rstart();
    send_byte(WADDR, ack);
    chk(ack, "R1 restart mid-byte ack", {7'h0, ack}, 8'h01);
    chk(!sda_oe, "R3 released after ack clock", {7'h0, sda_oe}, 8'h00);
    send_byte(8'h28, ack); // ch A, SD inactive, O1=1
    do_stop();
    chk(!sda_oe, "R1 released after stop", {7'h0, sda_oe}, 8'h00);
    send_byte(8'h44, ack);
    chk(!ack && wa == 8'h11, "R1 no ack without start", wa, 8'h11);

    // R6 repeated data bytes to channel B
    do_start();
    send_byte(WADDR, ack);
    send_byte(8'hA0, ack);
    send_byte(8'h0F, ack);
    send_byte(8'h3C, ack);
    send_byte(8'h33, ack);
    chk(ack, "R6 third data ack", {7'h0, ack}, 8'h01);
    do_stop();
    chk(wb == 8'h33, "R6 last byte kept", wb, 8'h33);
    chk(wa == 8'h11, "R6 other wiper kept", wa, 8'h11);

    // R7 streaming read: ack then nack
    do_start();
    send_byte(RADDR, ack);
    recv_byte(1'b1, rb);
    chk(rb == 8'h33, "R7 first byte", rb, 8'h33);
    recv_byte(1'b0, rb);
    chk(rb == 8'h33, "R7 second byte", rb, 8'h33);
    chk(!sda_oe, "R7 released after nack", {7'h0, sda_oe}, 8'h00);
    do_stop();

    // R5 midscale on channel A, combined with channel switch and read
    do_start();
    send_byte(WADDR, ack);
    send_byte(8'h60, ack); // ch A, midscale, SD inactive
    do_rstart();
    send_byte(RADDR, ack);
    recv_byte(1'b0, rb);
    do_stop();
    chk(wa == 8'h80, "R5 midscale loaded", wa, 8'h80);
    chk(rb == 8'h80, "R5 readback midscale", rb, 8'h80);
    chk(wb == 8'h33, "R5 other channel kept", wb, 8'h33);

    // R10 shutdown pin
    shdn_n = 1'b0; hold();
    chk(shd, "R10 pin asserts shutdown", {7'h0, shd}, 8'h01);
    chk(wa == 8'h80 && wb == 8'h33, "R10 wipers kept", wb, 8'h33);
    shdn_n = 1'b1; hold();
    chk(!shd, "R10 release", {7'h0, shd}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule